// File: doc/BRIEF.md
# Four-State Snooping Line Controller

This block tracks the coherence state of one line in a private cache that sits on a snooping bus. The line can be Invalid, Shared, Owned or Modified. The shared cache below this one is assumed to be expensive to write. For that reason a dirty line is handed directly to another cache when that cache asks for it. The line keeps its dirty data in the Owned state and writes it back only when it is evicted, or when another cache invalidates it while it is Owned.

The block has three interfaces:

- **Processor request port.** It takes read, write and evict requests.
- **Snoop input.** It reports read, read-for-ownership and invalidate transactions from other caches.
- **Bus command port.** The block issues its own bus commands here: read, read-for-ownership, invalidate, supply-data and write-back. Each command stays raised until the bus grants it.

A snoop always takes priority over a processor request in the same cycle. The processor request is then judged against the state the snoop leaves behind.

The states and transitions are:

- **Invalid**
  - read → issue BusRd, go to Shared
  - write → issue BusRdX, go to Modified
  - evict → completes at once
  - every snoop is ignored
- **Shared**
  - read hits
  - write → issue BusInv, go to Modified
  - snooped read-for-ownership or invalidate → Invalid, with no bus action
  - evict → Invalid, with no bus action
  - snooped read → no effect
- **Modified**
  - read and write hit
  - snooped read → supply data, go to Owned
  - snooped read-for-ownership → supply data, go to Invalid
  - snooped invalidate → write back, go to Invalid
  - evict → write back, go to Invalid
- **Owned**
  - read hits
  - write → issue BusInv, go to Modified
  - snooped read → supply data, stay Owned
  - snooped read-for-ownership → supply data, go to Invalid
  - snooped invalidate → write back, go to Invalid
  - evict → write back, go to Invalid

Top module: `mosi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid, `bus_req` is low and `cpu_done` is low. `line_state` encodes Invalid=0, Shared=1, Owned=2, Modified=3.
- R2: In Invalid, `cpu_op` codes are read=0, write=1 and evict=2. A read issues BusRd and moves to Shared. A write issues BusRdX and moves to Modified. An evict completes at once with no bus command and stays Invalid.
- R3: In Invalid, snoops have no effect: no bus command and no state change. Snoop codes are read=1, read-for-ownership=2 and invalidate=3; code 0 means no snoop.
- R4: In Shared, a write issues BusInv and moves to Modified. A snooped read-for-ownership or invalidate moves to Invalid with no bus command. An evict moves to Invalid with no bus command. A snooped read changes nothing.
- R5: In Modified, a snooped read issues supply-data and moves to Owned. A snooped read-for-ownership issues supply-data and moves to Invalid. A snooped invalidate issues a write-back and moves to Invalid.
- R6: In Owned, a snooped read issues supply-data and stays Owned. A snooped read-for-ownership issues supply-data and moves to Invalid. A snooped invalidate issues a write-back and moves to Invalid.
- R7: Evicting a line in Modified or Owned issues a write-back and moves to Invalid.
- R8: In Owned, a write issues BusInv and moves to Modified.
- R9: Reads hit in Shared, Owned and Modified, and writes hit in Modified. A hit completes (`cpu_done`=1) in the same cycle with no bus command and no state change.
- R10: A bus command stays raised while `bus_grant` is low, and its state change and processor completion happen only in the granted cycle. `bus_cmd` codes are BusRd=1, BusRdX=2, BusInv=3, supply-data=4, write-back=5.
- R11: A snoop is applied before a processor request in the same cycle, and the request is evaluated against the state the snoop leaves. While a snoop's own bus command is pending, or while it holds the bus in its granted cycle, a request that needs the bus does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Request kind: 0 read, 1 write, 2 evict |
| cpu_done | output | 1 | Request completes this cycle |
| snp_valid | input | 1 | Snooped transaction present; held by the bus until its reply is granted |
| snp_cmd | input | 2 | Snoop kind: 1 read, 2 read-for-ownership, 3 invalidate |
| bus_grant | input | 1 | Bus grants the command driven this cycle |
| bus_req | output | 1 | A bus command is being driven |
| bus_cmd | output | 3 | Command: 1 BusRd, 2 BusRdX, 3 BusInv, 4 supply-data, 5 write-back |
| line_state | output | 2 | Current line state: 0 I, 1 S, 2 O, 3 M |

## Verification
The hardest case to reach is a snoop and a processor request arriving in the same cycle when the snoop changes which bus command the request needs. Examples are a silent invalidate under a write in Shared, or a granted write-back under a write in Owned. The stimulus first steers the line into Shared, Owned or Modified using only granted processor and snoop traffic. It then raises both inputs together and withholds the grant for one cycle. This exposes the pending command, the stalled completion, and the state the snoop has already left.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_OWN = 2'd2,
        LN_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_RSVD  = 2'd3
    } cpu_op_t;

    typedef enum logic [1:0] {
        SN_NONE = 2'd0,
        SN_RD   = 2'd1,
        SN_RDX  = 2'd2,
        SN_INV  = 2'd3
    } snoop_t;

    typedef enum logic [2:0] {
        BC_NONE   = 3'd0,
        BC_RD     = 3'd1,
        BC_RDX    = 3'd2,
        BC_INV    = 3'd3,
        BC_SUPPLY = 3'd4,
        BC_WB     = 3'd5
    } bus_cmd_t;

    localparam int ST_W  = $bits(line_st_t);
    localparam int OP_W  = $bits(cpu_op_t);
    localparam int SN_W  = $bits(snoop_t);
    localparam int CMD_W = $bits(bus_cmd_t);

    typedef struct packed {
        line_st_t nxt;
        bus_cmd_t cmd;
    } xition_t;

endpackage

// File: rtl/mosi_snoop_rules.sv
module mosi_snoop_rules
    import mosi_pkg::*;
(
    input  line_st_t cur,
    input  snoop_t   sn,
    output xition_t  res
);
    always_comb begin
        res.nxt = cur;
        res.cmd = BC_NONE;
        unique case (cur)
            LN_INV: begin
                res.nxt = LN_INV;
            end
            LN_SHR: begin
                if (sn == SN_RDX || sn == SN_INV) begin
                    res.nxt = LN_INV;
                end
            end
            LN_MOD: begin
                unique case (sn)
                    SN_RD:   begin res.nxt = LN_OWN; res.cmd = BC_SUPPLY; end
                    SN_RDX:  begin res.nxt = LN_INV; res.cmd = BC_SUPPLY; end
                    SN_INV:  begin res.nxt = LN_INV; res.cmd = BC_WB;     end
                    default: begin res.nxt = LN_MOD; end
                endcase
            end
            LN_OWN: begin
                unique case (sn)
                    SN_RD:   begin res.nxt = LN_OWN; res.cmd = BC_SUPPLY; end
                    SN_RDX:  begin res.nxt = LN_INV; res.cmd = BC_SUPPLY; end
                    SN_INV:  begin res.nxt = LN_INV; res.cmd = BC_WB;     end
                    default: begin res.nxt = LN_OWN; end
                endcase
            end
            default: begin
                res.nxt = LN_INV;
            end
        endcase
    end
endmodule

// File: rtl/mosi_cpu_rules.sv
module mosi_cpu_rules
    import mosi_pkg::*;
(
    input  line_st_t cur,
    input  cpu_op_t  op,
    output xition_t  res
);
    always_comb begin
        res.nxt = cur;
        res.cmd = BC_NONE;
        unique case (cur)
            LN_INV: begin
                unique case (op)
                    OP_WRITE: begin res.nxt = LN_MOD; res.cmd = BC_RDX; end
                    OP_EVICT: begin res.nxt = LN_INV; end
                    default:  begin res.nxt = LN_SHR; res.cmd = BC_RD;  end
                endcase
            end
            LN_SHR: begin
                unique case (op)
                    OP_WRITE: begin res.nxt = LN_MOD; res.cmd = BC_INV; end
                    OP_EVICT: begin res.nxt = LN_INV; end
                    default:  begin res.nxt = LN_SHR; end
                endcase
            end
            LN_OWN: begin
                unique case (op)
                    OP_WRITE: begin res.nxt = LN_MOD; res.cmd = BC_INV; end
                    OP_EVICT: begin res.nxt = LN_INV; res.cmd = BC_WB;  end
                    default:  begin res.nxt = LN_OWN; end
                endcase
            end
            LN_MOD: begin
                unique case (op)
                    OP_EVICT: begin res.nxt = LN_INV; res.cmd = BC_WB; end
                    default:  begin res.nxt = LN_MOD; end
                endcase
            end
            default: begin
                res.nxt = LN_INV;
            end
        endcase
    end
endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl
    import mosi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [OP_W-1:0]  cpu_op,
    output logic             cpu_done,
    input  logic             snp_valid,
    input  logic [SN_W-1:0]  snp_cmd,
    input  logic             bus_grant,
    output logic             bus_req,
    output logic [CMD_W-1:0] bus_cmd,
    output logic [ST_W-1:0]  line_state
);
    line_st_t state_q, state_d;
    xition_t  sn_res, cpu_res;
    line_st_t view_st;
    logic     snoop_act, snoop_needs_bus, snoop_commit;
    bus_cmd_t cmd_d;

    assign snoop_act       = snp_valid && (snoop_t'(snp_cmd) != SN_NONE);
    assign snoop_needs_bus = snoop_act && (sn_res.cmd != BC_NONE);
    assign snoop_commit    = snoop_act && (!snoop_needs_bus || bus_grant);
    // processor request is judged against the post-snoop state
    assign view_st         = snoop_act ? sn_res.nxt : state_q;

    mosi_snoop_rules u_snoop (
        .cur (state_q),
        .sn  (snoop_t'(snp_cmd)),
        .res (sn_res)
    );

    mosi_cpu_rules u_cpu (
        .cur (view_st),
        .op  (cpu_op_t'(cpu_op)),
        .res (cpu_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_INV;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and next state
    always_comb begin
        bus_req  = 1'b0;
        cmd_d    = BC_NONE;
        cpu_done = 1'b0;
        state_d  = snoop_commit ? sn_res.nxt : state_q;
        if (snoop_needs_bus) begin
            bus_req = 1'b1;
            cmd_d   = sn_res.cmd;
            if (bus_grant && cpu_valid && cpu_res.cmd == BC_NONE) begin
                cpu_done = 1'b1;
            end
        end else if (cpu_valid) begin
            if (cpu_res.cmd != BC_NONE) begin
                bus_req  = 1'b1;
                cmd_d    = cpu_res.cmd;
                cpu_done = bus_grant;
            end else begin
                cpu_done = 1'b1;
            end
        end
        if (cpu_done) begin
            state_d = cpu_res.nxt;
        end
    end

    assign bus_cmd    = cmd_d;
    assign line_state = state_q;

endmodule

// File: rtl/mosi_line_ctrl_chk.sv
module mosi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic [1:0] cpu_op,
    input logic       cpu_done,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       bus_grant,
    input logic       bus_req,
    input logic [2:0] bus_cmd,
    input logic [1:0] line_state
);
    a_r3_invalid_ignores_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd0 && snp_valid && !cpu_valid) |-> !bus_req);

    a_r3_invalid_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd0 && snp_valid && !cpu_valid) |=> line_state == 2'd0);

    a_r5_modified_supplies: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd3 && snp_valid && snp_cmd == 2'd1) |-> (bus_req && bus_cmd == 3'd4));

    a_r7_evict_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state[1] && cpu_valid && cpu_op == 2'd2 && !snp_valid) |-> (bus_req && bus_cmd == 3'd5));

    a_r9_modified_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd3 && cpu_valid && cpu_op != 2'd2 && !snp_valid) |-> (cpu_done && !bus_req));

    a_r10_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant && !snp_valid) |=> line_state == $past(line_state));

    a_r10_done_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && bus_req && !snp_valid) |-> bus_grant);

    a_r11_stall_under_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && bus_req && bus_cmd >= 3'd4 && !bus_grant) |-> !cpu_done);
endmodule

bind mosi_line_ctrl mosi_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_op     (cpu_op),
    .cpu_done   (cpu_done),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .line_state (line_state)
);

// File: tb/mosi_line_ctrl_test.sv
module mosi_line_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic       cpu_done;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic       bus_grant = 1'b0;
    logic       bus_req;
    logic [2:0] bus_cmd;
    logic [1:0] line_state;

    int errors = 0;
    int checks = 0;

    localparam int RD = 0, WR = 1, EV = 2;
    localparam int S_I = 0, S_S = 1, S_O = 2, S_M = 3;

    always #5 clk = ~clk;

    mosi_line_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_done(cpu_done), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .bus_grant(bus_grant), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .line_state(line_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; combinational outputs sampled mid-cycle, state after the edge
    task automatic xact(input string tag, input int cv, input int op, input int sc,
                        input int g, input int e_req, input int e_cmd,
                        input int e_done, input int e_st);
        int o_req, o_cmd, o_done;
        @(negedge clk);
        cpu_valid = (cv != 0);
        cpu_op    = 2'(op);
        snp_valid = (sc != 0);
        snp_cmd   = 2'(sc);
        bus_grant = (g != 0);
        #1;
        o_req  = int'(bus_req);
        o_cmd  = bus_req ? int'(bus_cmd) : 0;
        o_done = int'(cpu_done);
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
        snp_valid = 1'b0;
        snp_cmd   = 2'd0;
        bus_grant = 1'b0;
        check({tag, " req"}, o_req, e_req);
        check({tag, " cmd"}, o_cmd, e_cmd);
        check({tag, " done"}, o_done, e_done);
        check({tag, " state"}, int'(line_state), e_st);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go_state(input int st);
        do_reset();
        if (st == S_S) xact("setup S", 1, RD, 0, 1, 1, 1, 1, S_S);
        if (st == S_M || st == S_O) xact("setup M", 1, WR, 0, 1, 1, 2, 1, S_M);
        if (st == S_O) xact("setup O", 0, 0, 1, 1, 1, 4, 0, S_O);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 state", int'(line_state), S_I);
        check("R1 req", int'(bus_req), 0);
        check("R1 done", int'(cpu_done), 0);
    endtask

    task automatic t_invalid_cpu();
        do_reset();
        xact("R10 read miss held", 1, RD, 0, 0, 1, 1, 0, S_I);
        xact("R2 read miss granted", 1, RD, 0, 1, 1, 1, 1, S_S);
        do_reset();
        xact("R2 write miss", 1, WR, 0, 1, 1, 2, 1, S_M);
        do_reset();
        xact("R2 evict invalid", 1, EV, 0, 0, 0, 0, 1, S_I);
    endtask

    task automatic t_invalid_snoop();
        do_reset();
        xact("R3 snoop rd", 0, 0, 1, 1, 0, 0, 0, S_I);
        xact("R3 snoop rdx", 0, 0, 2, 1, 0, 0, 0, S_I);
        xact("R3 snoop inv", 0, 0, 3, 1, 0, 0, 0, S_I);
    endtask

    task automatic t_shared();
        go_state(S_S);
        xact("R4 snoop rd no effect", 0, 0, 1, 1, 0, 0, 0, S_S);
        xact("R9 read hit S", 1, RD, 0, 0, 0, 0, 1, S_S);
        xact("R10 upgrade held", 1, WR, 0, 0, 1, 3, 0, S_S);
        xact("R4 upgrade granted", 1, WR, 0, 1, 1, 3, 1, S_M);
        go_state(S_S);
        xact("R4 snoop rdx", 0, 0, 2, 0, 0, 0, 0, S_I);
        go_state(S_S);
        xact("R4 snoop inv", 0, 0, 3, 0, 0, 0, 0, S_I);
        go_state(S_S);
        xact("R4 evict silent", 1, EV, 0, 0, 0, 0, 1, S_I);
    endtask

    task automatic t_modified();
        go_state(S_M);
        xact("R9 write hit M", 1, WR, 0, 0, 0, 0, 1, S_M);
        xact("R9 read hit M", 1, RD, 0, 0, 0, 0, 1, S_M);
        xact("R10 supply held", 0, 0, 1, 0, 1, 4, 0, S_M);
        xact("R5 snoop rd", 0, 0, 1, 1, 1, 4, 0, S_O);
        go_state(S_M);
        xact("R5 snoop rdx", 0, 0, 2, 1, 1, 4, 0, S_I);
        go_state(S_M);
        xact("R5 snoop inv", 0, 0, 3, 1, 1, 5, 0, S_I);
    endtask

    task automatic t_owned();
        go_state(S_O);
        xact("R9 read hit O", 1, RD, 0, 0, 0, 0, 1, S_O);
        xact("R6 snoop rd", 0, 0, 1, 1, 1, 4, 0, S_O);
        xact("R6 snoop rdx", 0, 0, 2, 1, 1, 4, 0, S_I);
        go_state(S_O);
        xact("R6 snoop inv held", 0, 0, 3, 0, 1, 5, 0, S_O);
        xact("R6 snoop inv", 0, 0, 3, 1, 1, 5, 0, S_I);
        go_state(S_O);
        xact("R8 write in O", 1, WR, 0, 1, 1, 3, 1, S_M);
    endtask

    task automatic t_evict();
        go_state(S_M);
        xact("R7 evict M held", 1, EV, 0, 0, 1, 5, 0, S_M);
        xact("R7 evict M", 1, EV, 0, 1, 1, 5, 1, S_I);
        go_state(S_O);
        xact("R7 evict O", 1, EV, 0, 1, 1, 5, 1, S_I);
    endtask

    task automatic t_collide();
        go_state(S_S);
        xact("R11 inv under write", 1, WR, 3, 0, 1, 2, 0, S_I);
        xact("R11 write after inv", 1, WR, 0, 1, 1, 2, 1, S_M);
        go_state(S_M);
        xact("R11 snoop rd stalls read", 1, RD, 1, 0, 1, 4, 0, S_M);
        xact("R11 read after supply", 1, RD, 1, 1, 1, 4, 1, S_O);
        go_state(S_O);
        xact("R11 wb holds bus", 1, WR, 3, 1, 1, 5, 0, S_I);
        xact("R11 write after wb", 1, WR, 0, 1, 1, 2, 1, S_M);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_invalid_cpu();
        t_invalid_snoop();
        t_shared();
        t_modified();
        t_owned();
        t_evict();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule